// File: doc/BRIEF.md
# Word Demultiplexer with Selectable Fan-out, Staggering and Pattern Test

The block takes one 11-bit word per clock, made of a 10-bit value and one side bit. It spreads consecutive words over up to four output lanes, numbered 0 to 3. A quad select sets whether two lanes or all four take part. A stagger select sets how the lanes update. In simultaneous mode every active lane changes on the same edge and one shared ready line marks it. In staggered mode each lane changes on the edge that captures its own word, and that lane's side-bit output turns into the lane's private strobe.

Every strobe can run in one of two ways. In pulse form it is high for one clock after an update. In toggle form it flips on each update, so both edges of the strobe mark fresh data.

A pattern-test select replaces the input with a fixed alternating checkerboard and forces all four lanes into use. A sleep input freezes capture. The asynchronous reset clears the outputs and realigns the lane order. Mode inputs are captured only while reset is held low. After reset is released, the block waits a fixed lead time before it captures its first word.

Top module: `word_demux`

## Requirements
- R1: Input word = {in_extra, in_data}; in_data bit 0 is the LSB. Accepted words go to lane 0, then lane 1, and then lanes 2 and 3 when four lanes are active. The sequence then wraps back to lane 0.
- R2: With cfg_quad low and cfg_selftest low, only lanes 0 and 1 carry words. out_data and out_aux of lanes 2 and 3 stay 0.
- R3: Simultaneous mode (cfg_stagger low): all active lanes load their words on the edge that captures the group's last word. Until then the lanes hold their previous values, and out_aux carries each lane's side bit.
- R4: Staggered mode (cfg_stagger high): a lane loads its word on the edge that captures that word. out_aux of each lane is that lane's own strobe. dready follows the updates of lane 0.
- R5: Pulse strobe form (cfg_halfrate low): dready, and each lane strobe in staggered mode, is 1 for the single cycle after its update edge and 0 otherwise.
- R6: Toggle strobe form (cfg_halfrate high): each strobe inverts on each of its update edges and otherwise holds.
- R7: Pattern test (cfg_selftest high): four lanes are active and the input value is ignored. Group k carries lanes 0, 1 and 3 = 10'b1010101010 and lane 2 = 10'b0101010101 for even k, and the bitwise inverse of these for odd k. The side bit is 0.
- R8: While arst_n is low, all outputs are 0 and the lane order restarts at lane 0. The cfg_* inputs are captured on clock edges during reset only; changes after release have no effect.
- R9: For the first LEAD_CYCLES clock edges after reset release, no word is captured and the outputs stay 0.
- R10: While sleep is high, no word is captured, lane outputs hold, the lane order does not advance, and pulse-form strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one word per rising edge |
| arst_n | input | 1 | Asynchronous reset, active low; mode capture window |
| cfg_quad | input | 1 | 1 = four lanes, 0 = two lanes |
| cfg_stagger | input | 1 | 1 = staggered lane updates, 0 = simultaneous |
| cfg_selftest | input | 1 | 1 = checkerboard pattern in place of input |
| cfg_halfrate | input | 1 | 1 = toggle-form strobes, 0 = pulse-form |
| sleep | input | 1 | Freeze capture and hold outputs |
| in_data | input | DW | Incoming data value |
| in_extra | input | 1 | Incoming side bit |
| out_data | output | NPORT x DW | Lane data, lane 0 in the lowest slice |
| out_aux | output | NPORT | Per lane: side bit, or lane strobe when staggered |
| dready | output | 1 | Shared data-ready strobe |

## Verification
The bench targets the lane-order restart after a reset asserted mid-group. A design that kept its slot counter would send the first word of the new run to a lane other than 0. It flips every cfg input right after release. A design that samples modes continuously would change fan-out or strobe form in mid-run, and the data and strobe checks would mismatch. It also checks the lead window, sleep bursts in mid-group, the checkerboard phase alternation with two-lane mode forced to four, and the toggle-form strobes. A design that slips the phase, drops a toggle, or lets sleep advance the lane order would show a wrong lane value or a wrong strobe level on the very next cycle.

// File: rtl/wdmx_pkg.sv
package wdmx_pkg;

  typedef struct packed {
    logic quad;
    logic stagger;
    logic selftest;
    logic halfrate;
  } wdmx_mode_t;

  // number of lanes taking part for a given fan-out choice
  function automatic int unsigned active_ports(logic quad, int unsigned nport);
    return quad ? nport : nport / 2;
  endfunction

  // checkerboard source: lane 2 is the complement of the others, odd groups invert
  function automatic logic [31:0] alt_pattern(int unsigned lane, logic phase);
    logic [31:0] base;
    base = {16{2'b10}};
    if (lane == 2) base = ~base;
    if (phase) base = ~base;
    return base;
  endfunction

endpackage

// File: rtl/wdmx_mode_hold.sv
module wdmx_mode_hold
  import wdmx_pkg::*;
#(
  parameter int LEAD_CYCLES = 15
) (
  input  logic       clk,
  input  logic       arst_n,
  input  wdmx_mode_t mode_in,
  output wdmx_mode_t mode_q,
  output logic       lead_done
);
  localparam int LW = $clog2(LEAD_CYCLES + 2);

  logic [LW-1:0] lead_cnt;

  // modes are captured only while reset is held
  always_ff @(posedge clk) begin
    if (!arst_n) mode_q <= mode_in;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         lead_cnt <= '0;
    else if (!lead_done) lead_cnt <= lead_cnt + 1'b1;
  end

  assign lead_done = (lead_cnt == LW'(LEAD_CYCLES));
endmodule

// File: rtl/wdmx_seq.sv
module wdmx_seq
  import wdmx_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  wdmx_mode_t       mode_q,
  input  logic             lead_done,
  input  logic             sleep,
  output logic             phase,
  output logic [NPORT-1:0] cap_en,
  output logic [NPORT-1:0] pub_en,
  output logic [NPORT-1:0] pub_direct,
  output logic             upd_evt
);
  localparam int SW = $clog2(NPORT);

  logic [SW-1:0] slot;
  logic [SW-1:0] last_slot;
  logic [SW:0]   n_active;
  logic          accept;
  logic          group_end;

  assign n_active  = (SW+1)'(active_ports(mode_q.quad | mode_q.selftest, NPORT));
  assign last_slot = SW'(n_active - 1'b1);
  assign accept    = lead_done & ~sleep;
  assign group_end = accept & (slot == last_slot);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      slot  <= '0;
      phase <= 1'b0;
    end else if (accept) begin
      slot <= group_end ? '0 : slot + 1'b1;
      if (group_end) phase <= ~phase;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_lane_ctl
    assign cap_en[p]     = accept & (slot == SW'(p));
    assign pub_en[p]     = mode_q.stagger ? cap_en[p]
                                          : (group_end & ((SW+1)'(p) < n_active));
    assign pub_direct[p] = mode_q.stagger | (SW'(p) == last_slot);
  end

  assign upd_evt = mode_q.stagger ? cap_en[0] : group_end;
endmodule

// File: rtl/wdmx_lane.sv
module wdmx_lane #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          cap_en,
  input  logic          pub_en,
  input  logic          pub_direct,
  input  logic          stagger,
  input  logic          halfrate,
  input  logic [DW:0]   word_in,
  output logic [DW-1:0] data_out,
  output logic          aux_out
);
  logic [DW:0] stage_q;
  logic [DW:0] hold_q;
  logic        strobe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q  <= '0;
      hold_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (cap_en) stage_q <= word_in;
      if (pub_en) begin
        hold_q   <= pub_direct ? word_in : stage_q;
        strobe_q <= halfrate ? ~strobe_q : 1'b1;
      end else if (!halfrate) begin
        strobe_q <= 1'b0;
      end
    end
  end

  assign data_out = hold_q[DW-1:0];
  assign aux_out  = stagger ? strobe_q : hold_q[DW];
endmodule

// File: rtl/wdmx_ready.sv
module wdmx_ready (
  input  logic clk,
  input  logic arst_n,
  input  logic upd_evt,
  input  logic halfrate,
  output logic dready
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        dready <= 1'b0;
    else if (upd_evt)   dready <= halfrate ? ~dready : 1'b1;
    else if (!halfrate) dready <= 1'b0;
  end
endmodule

// File: rtl/word_demux.sv
module word_demux
  import wdmx_pkg::*;
#(
  parameter int DW          = 10,
  parameter int NPORT       = 4,
  parameter int LEAD_CYCLES = 15
) (
  input  logic                      clk,
  input  logic                      arst_n,
  input  logic                      cfg_quad,
  input  logic                      cfg_stagger,
  input  logic                      cfg_selftest,
  input  logic                      cfg_halfrate,
  input  logic                      sleep,
  input  logic [DW-1:0]             in_data,
  input  logic                      in_extra,
  output logic [NPORT-1:0][DW-1:0]  out_data,
  output logic [NPORT-1:0]          out_aux,
  output logic                      dready
);
  wdmx_mode_t             mode_in;
  wdmx_mode_t             mode_q;
  logic                   lead_done;
  logic                   phase;
  logic                   upd_evt;
  logic [NPORT-1:0]       cap_en;
  logic [NPORT-1:0]       pub_en;
  logic [NPORT-1:0]       pub_direct;
  logic [NPORT-1:0][DW:0] lane_word;

  assign mode_in = '{quad: cfg_quad, stagger: cfg_stagger,
                     selftest: cfg_selftest, halfrate: cfg_halfrate};

  wdmx_mode_hold #(.LEAD_CYCLES(LEAD_CYCLES)) u_mode (
    .clk(clk), .arst_n(arst_n), .mode_in(mode_in),
    .mode_q(mode_q), .lead_done(lead_done)
  );

  wdmx_seq #(.NPORT(NPORT)) u_seq (
    .clk(clk), .arst_n(arst_n), .mode_q(mode_q), .lead_done(lead_done),
    .sleep(sleep), .phase(phase), .cap_en(cap_en), .pub_en(pub_en),
    .pub_direct(pub_direct), .upd_evt(upd_evt)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    assign lane_word[p] = mode_q.selftest ? {1'b0, DW'(alt_pattern(p, phase))}
                                          : {in_extra, in_data};

    wdmx_lane #(.DW(DW)) u_lane (
      .clk(clk), .arst_n(arst_n), .cap_en(cap_en[p]), .pub_en(pub_en[p]),
      .pub_direct(pub_direct[p]), .stagger(mode_q.stagger),
      .halfrate(mode_q.halfrate), .word_in(lane_word[p]),
      .data_out(out_data[p]), .aux_out(out_aux[p])
    );
  end

  wdmx_ready u_ready (
    .clk(clk), .arst_n(arst_n), .upd_evt(upd_evt),
    .halfrate(mode_q.halfrate), .dready(dready)
  );
endmodule

// File: rtl/wdmx_checker.sv
module wdmx_checker #(
  parameter int DW    = 10,
  parameter int NPORT = 4
) (
  input logic                     clk,
  input logic                     arst_n,
  input logic                     sleep,
  input logic                     lead_done,
  input logic                     upd_evt,
  input logic                     quad_q,
  input logic                     stagger_q,
  input logic                     selftest_q,
  input logic                     halfrate_q,
  input logic [NPORT-1:0][DW-1:0] out_data,
  input logic [NPORT-1:0]         out_aux,
  input logic                     dready
);
  localparam logic [DW-1:0] PAT_EVEN = DW'({16{2'b10}});

  // R2
  pair_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!quad_q && !selftest_q) |-> (out_data[NPORT-1:NPORT/2] == '0));

  // R3
  simul_change_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!stagger_q && !halfrate_q && !$stable(out_data)) |-> dready);

  // R4
  stagger_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (stagger_q && !halfrate_q) |-> $onehot0(out_aux));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!halfrate_q && dready) |=> !dready);

  // R6
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (halfrate_q && !upd_evt) |=> $stable(dready));

  // R7
  pattern_value_chk: assert property (@(posedge clk) disable iff (!arst_n)
    selftest_q |-> (out_data[0] == '0 || out_data[0] == PAT_EVEN || out_data[0] == ~PAT_EVEN));

  // R9
  lead_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !lead_done |=> (out_data == '0 && !dready));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sleep |=> $stable(out_data));
endmodule

bind word_demux wdmx_checker #(.DW(DW), .NPORT(NPORT)) u_wdmx_chk (
  .clk(clk), .arst_n(arst_n), .sleep(sleep), .lead_done(lead_done),
  .upd_evt(upd_evt), .quad_q(mode_q.quad), .stagger_q(mode_q.stagger),
  .selftest_q(mode_q.selftest), .halfrate_q(mode_q.halfrate),
  .out_data(out_data), .out_aux(out_aux), .dready(dready)
);

// File: tb/test_word_demux.sv
module test_word_demux;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 10;
  localparam int NP   = 4;
  localparam int LEAD = 15;
  localparam int WW   = DW + 1;
  localparam int NROW = 9;
  localparam int RUN  = 44;

  // row bits: {quad, stagger, selftest, halfrate, sleep burst}
  localparam logic [4:0] CFG [NROW] = '{
    5'b00001, 5'b10000, 5'b01000, 5'b11011, 5'b10010,
    5'b00010, 5'b00101, 5'b01110, 5'b01010
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic arst_n = 1'b0;
  logic cfg_quad = 1'b0, cfg_stagger = 1'b0, cfg_selftest = 1'b0, cfg_halfrate = 1'b0;
  logic sleep = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_extra = 1'b0;
  logic [NP-1:0][DW-1:0] out_data;
  logic [NP-1:0] out_aux;
  logic dready;

  word_demux #(.DW(DW), .NPORT(NP), .LEAD_CYCLES(LEAD)) i_word_demux (
    .clk(clk), .arst_n(arst_n), .cfg_quad(cfg_quad), .cfg_stagger(cfg_stagger),
    .cfg_selftest(cfg_selftest), .cfg_halfrate(cfg_halfrate), .sleep(sleep),
    .in_data(in_data), .in_extra(in_extra), .out_data(out_data),
    .out_aux(out_aux), .dready(dready)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic c_quad, c_stag, c_st, c_half;
  logic [NP-1:0][DW:0]   m_stage;
  logic [NP-1:0][DW-1:0] m_data;
  logic [NP-1:0]         m_side, m_strobe;
  logic m_dr, m_phase, m_slept;
  int   m_slot, edges;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_pat(int lane, logic ph);
    logic [DW-1:0] v;
    v = (lane == 2) ? 10'b0101010101 : 10'b1010101010;
    return ph ? ~v : v;
  endfunction

  task automatic model_clear();
    m_stage = '0; m_data = '0; m_side = '0; m_strobe = '0;
    m_dr = 1'b0; m_phase = 1'b0; m_slot = 0; edges = 0;
  endtask

  task automatic model_edge(input logic [DW:0] w, input logic slp);
    int n;
    logic [DW:0] eff;
    edges++;
    n = (c_quad || c_st) ? 4 : 2;
    if (edges > LEAD && !slp) begin
      eff = c_st ? {1'b0, ref_pat(m_slot, m_phase)} : w;
      if (c_stag) begin
        for (int j = 0; j < NP; j++) if (!c_half && j != m_slot) m_strobe[j] = 1'b0;
        m_data[m_slot] = eff[DW-1:0];
        m_side[m_slot] = eff[DW];
        m_strobe[m_slot] = c_half ? ~m_strobe[m_slot] : 1'b1;
        if (m_slot == 0) m_dr = c_half ? ~m_dr : 1'b1;
        else if (!c_half) m_dr = 1'b0;
      end else begin
        m_stage[m_slot] = eff;
        if (m_slot == n - 1) begin
          for (int j = 0; j < n; j++) begin
            m_data[j] = m_stage[j][DW-1:0];
            m_side[j] = m_stage[j][DW];
          end
          m_dr = c_half ? ~m_dr : 1'b1;
        end else if (!c_half) m_dr = 1'b0;
      end
      if (m_slot == n - 1) begin
        m_slot = 0;
        m_phase = ~m_phase;
      end else m_slot++;
    end else if (!c_half) begin
      m_dr = 1'b0;
      m_strobe = '0;
    end
  endtask

  task automatic compare();
    string tag;
    logic exp_aux;
    for (int p = 0; p < NP; p++) begin
      if (edges <= LEAD)                         tag = "R9";
      else if (m_slept)                          tag = "R10";
      else if (c_st)                             tag = "R7";
      else if (!c_quad && p >= 2)                tag = "R2";
      else if (c_stag)                           tag = "R4";
      else                                       tag = "R3";
      check(out_data[p] == m_data[p], tag, $sformatf("lane%0d data", p),
            int'(out_data[p]), int'(m_data[p]));
      exp_aux = c_stag ? m_strobe[p] : m_side[p];
      check(out_aux[p] == exp_aux, c_stag ? (c_half ? "R6" : "R4") : "R1",
            $sformatf("lane%0d aux", p), int'(out_aux[p]), int'(exp_aux));
    end
    check(dready == m_dr, c_half ? "R6" : "R5", "dready", int'(dready), int'(m_dr));
  endtask

  task automatic step(input logic [DW:0] w, input logic slp);
    in_data  = w[DW-1:0];
    in_extra = w[DW];
    sleep    = slp;
    @(posedge clk);
    model_edge(w, slp);
    m_slept = slp;
    @(negedge clk);
    compare();
  endtask

  // R8: outputs cleared, modes captured only during reset
  task automatic do_reset(input logic [4:0] cfg);
    @(negedge clk);
    arst_n = 1'b0;
    sleep = 1'b0;
    {cfg_quad, cfg_stagger, cfg_selftest, cfg_halfrate} = cfg[4:1];
    {c_quad, c_stag, c_st, c_half} = cfg[4:1];
    #1;
    check(out_data == '0 && out_aux == '0 && dready == 1'b0, "R8", "async clear",
          int'(out_data[0]) | int'(out_aux) | int'(dready), 0);
    repeat (3) @(negedge clk);
    check(out_data == '0 && dready == 1'b0, "R8", "held in reset",
          int'(out_data[0]), 0);
    model_clear();
    m_slept = 1'b0;
    arst_n = 1'b1;
    // R8: flipping modes after release must not matter
    {cfg_quad, cfg_stagger, cfg_selftest, cfg_halfrate} = ~cfg[4:1];
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [DW:0] w;
    repeat (2) @(negedge clk);
    for (int r = 0; r < NROW; r++) begin
      do_reset(CFG[r]);
      for (int k = 0; k < RUN; k++) begin
        w = WW'(r * 131 + k * 29 + 7);
        step(w, CFG[r][0] && (k >= 24) && (k <= 26));
      end
    end

    // R1: extreme words, reset mid-group must restart at lane 0
    do_reset(5'b10000);
    for (int k = 0; k < LEAD + 2; k++) step(k[0] ? '1 : '0, 1'b0);
    do_reset(5'b10000);
    for (int k = 0; k < LEAD + 8; k++) step(WW'(k + 1), 1'b0);
    check(out_data[0] == DW'(LEAD + 5), "R1", "lane0 after realign",
          int'(out_data[0]), LEAD + 5);

    // R10: sleep held through the lead window and into a group
    do_reset(5'b01000);
    for (int k = 0; k < LEAD + 12; k++) step(WW'(3 * k), (k >= LEAD - 2) && (k <= LEAD + 3));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule